// File: doc/BRIEF.md
# Handshake and Bounded-Response Temporal Monitor

This block is a synthesizable run-time checker placed beside a design to watch four of its signals on every rising clock edge. It evaluates two fixed temporal rules at the same time. The handshake rule says that once a request is followed by an acknowledge one cycle later, and then by a cycle with halt low, grant must be high for two consecutive cycles. The response rule says that every request must see an acknowledge in the same cycle or within the next two cycles.

Each rule may start a new attempt on every clock cycle, so partial matches and open obligations are held in short per-cycle shift registers. Attempts started on neighbouring cycles are therefore judged independently. For every attempt and every cycle the monitor reports one of three outcomes. A violation raises a one-cycle fail strobe. Meeting all obligations raises a one-cycle pass strobe. While obligations are still open, a pending flag is raised. A separate abort input throws away every attempt in progress without reporting it. A saturating error counter per rule records how many cycles carried a violation.

The mode input chooses where the handshake rule's grant window begins. It can start in the cycle in which the halt-low condition completes the trigger, or one cycle later. The mode should only be changed in a cycle where abort is high.

Top module: `temporal_monitor`

## Requirements
- R1: With nonOverlap low, a handshake attempt is req high in cycle t, ack high in t+1 and halt low in t+2. It needs grant high in t+2 and t+3. A low grant in t+2 raises failA in t+2. If grant was high in t+2, a low grant in t+3 raises failA in t+3.
- R2: With nonOverlap high, the trigger is the same as in R1, but the two grant checks move to t+3 and t+4, with failA raised in the cycle whose grant is low. No grant check happens in t+2.
- R3: passA pulses for one cycle, in the cycle of an attempt's second grant check, when grant is high in both of its check cycles. failA and passA are never high together.
- R4: A req in cycle t is met by ack in t, t+1 or t+2. passB pulses in any cycle in which ack is high while a request is open or arrives. If ack stays low from t through t+2, failB pulses in t+2.
- R5: Attempts that start in consecutive cycles are tracked and reported independently of each other.
- R6: In a cycle where abortIn is high, no fail or pass strobe is raised. Every attempt begun in or before that cycle is discarded and never reports. The pending flags are low in the next cycle.
- R7: pendA is high in a cycle when a handshake attempt whose trigger completed earlier still has a grant check due in that cycle. pendB is high when a request from an earlier cycle is still waiting for ack.
- R8: errCntA and errCntB rise by one in the cycle after each cycle in which their fail strobe is high, and otherwise hold. They saturate at 65535.
- R9: A low rstN at a rising edge clears all trackers, pending flags and counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, sampled on rising edges |
| rstN | input | 1 | Active-low synchronous reset |
| abortIn | input | 1 | Discards every attempt in progress |
| nonOverlap | input | 1 | 1: grant window starts one cycle after the trigger completes |
| req | input | 1 | Watched request signal |
| ack | input | 1 | Watched acknowledge signal |
| halt | input | 1 | Watched halt signal |
| grant | input | 1 | Watched grant signal |
| failA | output | 1 | Handshake rule violated this cycle |
| passA | output | 1 | A handshake attempt met all obligations this cycle |
| pendA | output | 1 | A handshake grant check is due this cycle |
| failB | output | 1 | Response rule violated this cycle |
| passB | output | 1 | An open request was answered this cycle |
| pendB | output | 1 | A request from an earlier cycle is still open |
| errCntA | output | 16 | Saturating count of handshake violation cycles |
| errCntB | output | 16 | Saturating count of response violation cycles |

## Verification
On every cycle the assertions check local facts. A handshake failure needs a low grant, and a pass needs two high grants. A response failure needs three quiet ack cycles, and a request answered in its own cycle passes at once. Abort keeps the strobes silent and empties the pending state, and the counters move only in step with their fail strobes. Only the bench's scenarios can show that fails and passes land in exactly the right cycle for each mode. The same goes for overlapping attempts started back to back each being judged once, for attempts started before an abort staying silent afterwards, and for the counters stopping at their saturation value. The bench shows these by comparing every output in every cycle against a model built from the input history.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  localparam int NUM_PROP = 2;

  // Per-cycle verdicts of the control block
  typedef struct packed {
    logic failA;
    logic passA;
    logic pendA;
    logic failB;
    logic passB;
    logic pendB;
  } tmon_verdict_t;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic bumpB;
    logic bumpA;
  } tmon_bump_t;
endpackage

// File: rtl/tmon_ctrl.sv
module tmon_ctrl
  import tmon_pkg::*;
#(
  parameter int ACK_WIN = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          abortIn,
  input  logic          nonOverlap,
  input  logic          req,
  input  logic          ack,
  input  logic          halt,
  input  logic          grant,
  output tmon_verdict_t verdict,
  output tmon_bump_t    bump
);
  // Handshake trigger stages: request seen, request then acknowledge seen
  logic reqSeen;
  logic reqAckSeen;
  // Grant obligations: first check deferred (nonOverlap), second check due
  logic firstDue;
  logic secondDue;
  // Response rule: waitB[k] = request k cycles ago with no ack since
  logic [ACK_WIN:1] waitB;
  logic [ACK_WIN:1] waitNext;

  logic active;
  logic trigDone;
  logic firstChk;
  logic failNowA;
  logic failNowB;

  assign active   = rstN & ~abortIn;
  assign trigDone = reqAckSeen & ~halt;
  assign firstChk = nonOverlap ? firstDue : trigDone;

  for (genvar k = 1; k <= ACK_WIN; k++) begin : g_wait
    if (k == 1) begin : g_head
      assign waitNext[k] = req & ~ack;
    end else begin : g_tail
      assign waitNext[k] = waitB[k-1] & ~ack;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || abortIn) begin
      reqSeen    <= 1'b0;
      reqAckSeen <= 1'b0;
      firstDue   <= 1'b0;
      secondDue  <= 1'b0;
      waitB      <= '0;
    end else begin
      reqSeen    <= req;
      reqAckSeen <= reqSeen & ack;
      firstDue   <= trigDone;
      secondDue  <= firstChk & grant;
      waitB      <= waitNext;
    end
  end

  assign failNowA = active & ~grant & (firstChk | secondDue);
  assign failNowB = active & waitB[ACK_WIN] & ~ack;

  always_comb begin
    verdict.failA = failNowA;
    verdict.passA = active & secondDue & grant;
    verdict.pendA = (nonOverlap & firstDue) | secondDue;
    verdict.failB = failNowB;
    verdict.passB = active & ack & (req | (|waitB));
    verdict.pendB = |waitB;
    bump.bumpA    = failNowA;
    bump.bumpB    = failNowB;
  end
endmodule

// File: rtl/tmon_dp.sv
module tmon_dp
  import tmon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  tmon_bump_t                       bump,
  output logic [NUM_PROP-1:0][CNT_W-1:0]   errCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_PROP-1:0] bumpVec;
  assign bumpVec = {bump.bumpB, bump.bumpA};

  for (genvar p = 0; p < NUM_PROP; p++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN) begin
        errCnt[p] <= '0;
      end else if (bumpVec[p] && errCnt[p] != CNT_MAX) begin
        errCnt[p] <= errCnt[p] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/temporal_monitor.sv
module temporal_monitor
  import tmon_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int ACK_WIN = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             abortIn,
  input  logic             nonOverlap,
  input  logic             req,
  input  logic             ack,
  input  logic             halt,
  input  logic             grant,
  output logic             failA,
  output logic             passA,
  output logic             pendA,
  output logic             failB,
  output logic             passB,
  output logic             pendB,
  output logic [CNT_W-1:0] errCntA,
  output logic [CNT_W-1:0] errCntB
);
  tmon_verdict_t                     verdict;
  tmon_bump_t                        bump;
  logic [NUM_PROP-1:0][CNT_W-1:0]    errCnt;

  tmon_ctrl #(.ACK_WIN(ACK_WIN)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .abortIn   (abortIn),
    .nonOverlap(nonOverlap),
    .req       (req),
    .ack       (ack),
    .halt      (halt),
    .grant     (grant),
    .verdict   (verdict),
    .bump      (bump)
  );

  tmon_dp #(.CNT_W(CNT_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .bump  (bump),
    .errCnt(errCnt)
  );

  assign failA   = verdict.failA;
  assign passA   = verdict.passA;
  assign pendA   = verdict.pendA;
  assign failB   = verdict.failB;
  assign passB   = verdict.passB;
  assign pendB   = verdict.pendB;
  assign errCntA = errCnt[0];
  assign errCntB = errCnt[1];
endmodule

// File: rtl/tmon_checker.sv
module tmon_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             abortIn,
  input logic             req,
  input logic             ack,
  input logic             grant,
  input logic             failA,
  input logic             passA,
  input logic             pendA,
  input logic             failB,
  input logic             passB,
  input logic             pendB,
  input logic [CNT_W-1:0] errCntA,
  input logic [CNT_W-1:0] errCntB
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  AST_FAILA_LOW_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    failA |-> !grant); // R1
  AST_PASSA_TWO_GRANTS: assert property (@(posedge clk) disable iff (!rstN)
    passA |-> (grant && $past(grant))); // R3
  AST_A_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(failA && passA)); // R3
  AST_FAILB_QUIET_ACK: assert property (@(posedge clk) disable iff (!rstN)
    failB |-> (!ack && !$past(ack) && !$past(ack, 2))); // R4
  AST_PASSB_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (req && ack && !abortIn) |-> passB); // R4
  AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    abortIn |-> !(failA || passA || failB || passB)); // R6
  AST_ABORT_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    abortIn |=> (!pendA && !pendB)); // R6
  AST_CNTA_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (failA && errCntA != SAT) |=> (errCntA == $past(errCntA) + 1'b1)); // R8
  AST_CNTA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !failA |=> $stable(errCntA)); // R8
  AST_CNTB_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (failB && errCntB != SAT) |=> (errCntB == $past(errCntB) + 1'b1)); // R8
  AST_CNTB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !failB |=> $stable(errCntB)); // R8
endmodule

bind temporal_monitor tmon_checker #(.CNT_W(CNT_W)) u_tmonChk (
  .clk    (clk),
  .rstN   (rstN),
  .abortIn(abortIn),
  .req    (req),
  .ack    (ack),
  .grant  (grant),
  .failA  (failA),
  .passA  (passA),
  .pendA  (pendA),
  .failB  (failB),
  .passB  (passB),
  .pendB  (pendB),
  .errCntA(errCntA),
  .errCntB(errCntB)
);

// File: tb/temporal_monitor_bench.sv
`timescale 1ns/1ps
module temporal_monitor_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic abortIn = 1'b0;
  logic nonOverlap = 1'b0;
  logic req = 1'b0, ack = 1'b0, halt = 1'b0, grant = 1'b0;
  logic failA, passA, pendA, failB, passB, pendB;
  logic [15:0] errCntA, errCntB;

  temporal_monitor u_temporal_monitor (
    .clk(clk), .rstN(rstN), .abortIn(abortIn), .nonOverlap(nonOverlap),
    .req(req), .ack(ack), .halt(halt), .grant(grant),
    .failA(failA), .passA(passA), .pendA(pendA),
    .failB(failB), .passB(passB), .pendB(pendB),
    .errCntA(errCntA), .errCntB(errCntB)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit curMode = 1'b0;
  // History shift vectors: bit k = value k cycles ago (0 = this cycle)
  logic [15:0] hReq = '0, hAck = '0, hHalt = '0, hGnt = '0, hAb = '1;
  int expCntA = 0, expCntB = 0;
  int seenPassA = 0, seenFailA = 0, seenFailB = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit noAbort(int lo, int hi);
    for (int k = lo; k <= hi; k++) if (hAb[k]) return 1'b0;
    return 1'b1;
  endfunction

  // Handshake trigger completed k cycles ago (R1/R2 trigger)
  function automatic bit trigAt(int k);
    return hReq[k+2] && hAck[k+1] && !hHalt[k] && noAbort(k, k+2);
  endfunction

  // A first grant check falls k cycles ago
  function automatic bit firstAt(int k);
    if (curMode) return trigAt(k+1) && !hAb[k];
    return trigAt(k);
  endfunction

  // Request j cycles ago still open at the start of this cycle
  function automatic bit waitAt(int j);
    if (!hReq[j]) return 1'b0;
    for (int k = 1; k <= j; k++) if (hAck[k] || hAb[k]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic step(bit rn, bit r, bit a, bit h, bit g, bit ab);
    bit eFailA, ePassA, ePendA, eFailB, ePassB, ePendB;
    @(negedge clk);
    rstN = rn; req = r; ack = a; halt = h; grant = g; abortIn = ab;
    nonOverlap = curMode;
    hReq = {hReq[14:0], r}; hAck = {hAck[14:0], a}; hHalt = {hHalt[14:0], h};
    hGnt = {hGnt[14:0], g}; hAb = {hAb[14:0], ab | !rn};
    #1;
    if (!rn) begin
      expCntA = 0; expCntB = 0;
    end else begin
      eFailA = !hAb[0] && !g && (firstAt(0) || (firstAt(1) && hGnt[1]));
      ePassA = !hAb[0] && g && firstAt(1) && hGnt[1];
      ePendA = (curMode && trigAt(1)) || (firstAt(1) && hGnt[1]);
      eFailB = !hAb[0] && !a && waitAt(2);
      ePassB = !hAb[0] && a && (r || waitAt(1) || waitAt(2));
      ePendB = waitAt(1) || waitAt(2);
      chk(curMode ? "R2 failA" : "R1 failA", int'(failA), int'(eFailA));
      chk("R3 passA", int'(passA), int'(ePassA));
      chk("R7 pendA", int'(pendA), int'(ePendA));
      chk("R4 failB", int'(failB), int'(eFailB));
      chk("R4 passB", int'(passB), int'(ePassB));
      chk("R7 pendB", int'(pendB), int'(ePendB));
      chk("R8 errCntA", int'(errCntA), expCntA);
      chk("R8 errCntB", int'(errCntB), expCntB);
      if (eFailA && expCntA != 65535) expCntA++;
      if (eFailB && expCntB != 65535) expCntB++;
      seenPassA += int'(passA);
      seenFailA += int'(failA);
      seenFailB += int'(failB);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0);
  endtask

  task automatic randomRun(int n);
    for (int i = 0; i < n; i++)
      step(1, ($urandom % 10) < 4, ($urandom % 10) < 4, ($urandom % 10) < 3,
           ($urandom % 10) < 7, ($urandom % 100) < 3);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    // R9: reset state
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    chk("R9 errCntA", int'(errCntA), 0);
    chk("R9 errCntB", int'(errCntB), 0);
    chk("R9 pendA", int'(pendA), 0);
    chk("R9 pendB", int'(pendB), 0);

    // R5: two handshake attempts started on consecutive cycles (overlap mode)
    idle(4);
    seenPassA = 0;
    step(1, 1, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0);
    step(1, 0, 1, 0, 1, 0);
    step(1, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 1, 0);
    chk("R5 passA count", seenPassA, 2);

    // R6: abort on the completing cycle hides a would-be failure
    idle(4);
    seenFailA = 0; seenFailB = 0;
    step(1, 1, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 1);
    chk("R6 pendA flushed", int'(pendA), 0);
    step(1, 0, 0, 0, 0, 0);
    chk("R6 pendA after abort", int'(pendA), 0);
    step(1, 1, 0, 0, 0, 1);
    idle(4);
    chk("R6 failA count", seenFailA, 0);
    chk("R6 failB count", seenFailB, 0);

    randomRun(3000);

    // R2: switch mode under abort, then a late grant miss
    step(1, 0, 0, 0, 0, 1);
    curMode = 1'b1;
    idle(4);
    step(1, 1, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    chk("R2 no check in trigger cycle", int'(failA), 0);
    step(1, 0, 0, 0, 0, 0);
    chk("R2 late grant miss", int'(failA), 1);

    randomRun(3000);

    // R8: saturation of the response counter
    step(1, 0, 0, 0, 0, 1);
    for (int i = 0; i < 65540; i++) step(1, 1, 0, 0, 0, 0);
    chk("R8 errCntB saturated", int'(errCntB), 65535);
    idle(3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule